// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates one group of clock outputs from an asynchronous, active-low stop request. The request crosses into the controlled clock domain through a parameterized flop synchronizer. A small state machine then decides, once per source-clock rising edge, whether the stoppable outputs may run. Every output passes through a gate cell. Each cell holds a latch that is transparent only while the source clock is low, and the latch output is ANDed with the clock. Enable changes therefore land only in the low phase. A gated output parks at logic 0 and always restarts with a full-width high phase.

Each output has two controls. An enable bit holds that output low whatever the stop state. A free-running bit lets that output ignore the stop request. A status output reports when every stoppable output in the group is parked. A fast processor-clock group and a slower bus-clock group each use their own instance, with different synchronizer depths and output counts.

The state machine has three states:
- RUN: stoppable outputs pulse. RUN moves to HALT when the synchronized request is active.
- HALT: stoppable outputs are suppressed and the gates are draining. HALT always moves to PARK on the next edge.
- PARK: outputs are parked and status is high. PARK stays in PARK while the request is active and returns to RUN when it is released.

Top module: `clk_stop_gate`

## Requirements
- R1: The stop input passes through SYNC_STAGES flops (default 2) before the state machine sees it. Let edge k be the first rising edge that samples stop_ni low while the block is running. Stoppable enabled outputs then pulse at edges k through k+SYNC_STAGES, and do not pulse from edge k+SYNC_STAGES+1 on. With the default depth this is fewer than 4 source clocks.
- R2: After a stop lasting at least two sampled edges, let edge k be the first edge that samples stop_ni high. The first restored pulse of the stoppable outputs comes at edge k+SYNC_STAGES+1.
- R3: A stopped output is logic 0 in both clock phases.
- R4: No output is ever high while clk_i is low, so every output pulse is a complete high phase of clk_i.
- R5: Once HALT is entered, the stoppable outputs stay suppressed for at least two rising edges. A stop request sampled low at a single edge k removes exactly the pulses at edges k+SYNC_STAGES+1 and k+SYNC_STAGES+2.
- R6: An output whose free_i bit is 1 keeps pulsing during a stop. An output whose free_i bit is 0 obeys the stop. Bit i of free_i controls clk_o[i].
- R7: An output whose en_i bit is 0 is held low. A change to en_i or free_i made while clk_i is high takes effect at the rising edge that follows the next low phase. Bit i controls clk_o[i].
- R8: After rising edge j, stopped_o is 1 exactly when the stoppable outputs miss their pulse at edge j and also at edge j+1, which is the PARK state. stopped_o depends on the stop state only, not on the masks.
- R9: While rst_ni is low, the block is in RUN, the synchronizer reads "not stopped", stopped_o is 0, and each clk_o[i] follows clk_i ANDed with en_i[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock of the group |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| en_i | input | N_OUT | Per-output enable; 0 holds the output low |
| free_i | input | N_OUT | Per-output free-running select; 1 ignores the stop |
| clk_o | output | N_OUT | Gated clock outputs |
| stopped_o | output | 1 | High while all stoppable outputs are parked |

## Verification
The hardest situation to reach from the ports is a stop request released while the state machine is still in HALT, where the minimum two-edge suppression must win over the release. The bench drives one-edge-wide and wider low pulses on stop_ni, each followed by a long high gap. It predicts the missing pulses from a short shift history of sampled stop levels. It also sweeps every enable and free-running mask combination, and checks both clock phases at every edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_PARK = 2'd2
    } gate_state_e;
endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_ni,
    output logic sync_no
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= async_ni;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
    import clkgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_req_i,
    output logic run_o,
    output logic parked_o
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop_req_i) state_d = ST_HALT;
            ST_HALT: state_d = ST_PARK;
            ST_PARK: if (!stop_req_i) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o    = 1'b0;
        parked_o = 1'b0;
        unique case (state_q)
            ST_RUN:  run_o    = 1'b1;
            ST_HALT: ;
            ST_PARK: parked_o = 1'b1;
            default: run_o    = 1'b1;
        endcase
    end
endmodule

// File: rtl/gate_cell.sv
module gate_cell (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);
    logic en_lat;

    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_ni,
    input  logic [N_OUT-1:0] en_i,
    input  logic [N_OUT-1:0] free_i,
    output logic [N_OUT-1:0] clk_o,
    output logic             stopped_o
);
    logic stop_sync_n;
    logic run;
    logic parked;

    stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .async_ni (stop_ni),
        .sync_no  (stop_sync_n)
    );

    stop_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stop_req_i (!stop_sync_n),
        .run_o      (run),
        .parked_o   (parked)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        gate_cell u_cell (
            .clk_i (clk_i),
            .en_i  (en_i[g] & (run | free_i[g])),
            .clk_o (clk_o[g])
        );
    end

    assign stopped_o = parked;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             stop_ni,
    input logic [N_OUT-1:0] en_i,
    input logic [N_OUT-1:0] free_i,
    input logic [N_OUT-1:0] clk_o,
    input logic             stopped_o
);
    localparam int LIM = SYNC_STAGES + 3;
    localparam int CW  = $clog2(LIM + 1) + 1;

    logic [CW-1:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= stop_ni ? '0 : ((lo_cnt < CW'(LIM)) ? lo_cnt + 1'b1 : lo_cnt);
            hi_cnt <= stop_ni ? ((hi_cnt < CW'(LIM)) ? hi_cnt + 1'b1 : hi_cnt) : '0;
        end
    end

    // R4
    low_phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_o == '0);

    // R1
    stop_reaches_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_cnt >= CW'(SYNC_STAGES + 2)) |-> stopped_o);

    // R2
    release_leaves_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_cnt >= CW'(SYNC_STAGES + 3)) |-> !stopped_o);

    // R3
    parked_outputs_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        stopped_o |-> ((clk_o & ~$past(free_i)) == '0));

    // R7
    disabled_held_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (clk_o & ~$past(en_i)) == '0);

    // R6
    free_keeps_running_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (($past(en_i) & $past(free_i)) & ~clk_o) == '0);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
    .N_OUT       (N_OUT),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (stop_ni),
    .en_i      (en_i),
    .free_i    (free_i),
    .clk_o     (clk_o),
    .stopped_o (stopped_o)
);

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
    localparam int N  = 4;
    localparam int SS = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic [N-1:0] en = '1;
    logic [N-1:0] free = '0;
    logic [N-1:0] clk_o;
    logic         stopped;

    int vectors = 0;
    int errs    = 0;
    logic [7:0] h = '1;   // h[d]: stop_n sampled d edges ago (h[0] = this edge)

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(SS)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n),
        .en_i(en), .free_i(free), .clk_o(clk_o), .stopped_o(stopped)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Advance one edge, apply next inputs just after it, check both phases.
    task automatic step(input logic n_stop, input logic [N-1:0] n_en,
                        input logic [N-1:0] n_free, input string req);
        logic [N-1:0] le, lf;
        logic off_e, off_n;
        @(posedge clk);
        h  = {h[6:0], stop_n};
        le = en;
        lf = free;
        #1;
        stop_n = n_stop; en = n_en; free = n_free;
        #4;
        // pulse at edge e missing if low SS+1 edges ago, or low began SS+2 edges ago
        off_e = ~h[SS+1] | (~h[SS+2] & h[SS+3]);
        off_n = ~h[SS]   | (~h[SS+1] & h[SS+2]);
        chk({req, " high phase"}, 32'(clk_o), 32'(le & (off_e ? lf : {N{1'b1}})));
        chk("R8 stopped", 32'(stopped), 32'(off_e & off_n));
        #10;
        chk("R4 R3 low phase", 32'(clk_o), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        en = 4'b1011;
        repeat (3) @(posedge clk);
        #5;
        chk("R9 reset stopped", 32'(stopped), 32'd0);
        chk("R9 reset outputs", 32'(clk_o), 32'(4'b1011));
        @(posedge clk);
        #1 rst_n = 1'b1;
        en = '1;
        step(1'b1, '1, '0, "R9");
        step(1'b1, '1, '0, "R9");

        // R6 R7: every enable and free mask while running
        for (int m = 0; m < 256; m++) begin
            step(1'b1, 4'(m), 4'(m >> 4), "R7 R6 sweep");
        end
        step(1'b1, '1, '0, "R7");

        // R1 R2 R5: low pulses of width 1..6, each with a long high gap
        for (int f = 0; f < 4; f++) begin
            logic [N-1:0] fm;
            fm = (f == 0) ? 4'b0000 : (f == 1) ? 4'b0100 : (f == 2) ? 4'b1001 : 4'b1111;
            for (int w = 1; w <= 6; w++) begin
                for (int i = 0; i < w; i++)
                    step(1'b0, (f == 3) ? 4'b0110 : 4'b1111, fm, "R1 R5 R6 stop");
                for (int i = 0; i < 8; i++)
                    step(1'b1, (f == 3) ? 4'b0110 : 4'b1111, fm, "R2 R5 restart");
            end
        end

        // R7: mask changes while parked
        for (int i = 0; i < 6; i++) step(1'b0, '1, '0, "R1 stop");
        for (int m = 0; m < 16; m++) step(1'b0, 4'(m), 4'(15 - m), "R7 R3 parked masks");
        for (int i = 0; i < 8; i++) step(1'b1, '1, '0, "R2 restart");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule